// File: doc/BRIEF.md
# Machine-Mode Trap and Privilege Controller

This block carries the trap-entry and trap-return state of a small 32-bit core that runs at machine (M) or user (U) privilege. Each cycle it receives the decode flags of the instruction that is retiring: wait-for-interrupt, debug-return, machine-return and illegal. It also receives that instruction's PC, instruction-fetch and store access fault strobes, a debug-mode indication, and one interrupt request with its ID. It holds the privilege level, the interrupt enable, the previous enable, the previous privilege and the timeout-wait (TW) fields of the machine status word, plus the trap cause, the exception PC and the trap vector base.

When it takes a trap, it records a cause word and the PC, saves the privilege, disables interrupts, enters M-mode and raises a redirect to the vector base in the same cycle. A machine-return restores the saved state and redirects to the saved PC. A wait-for-interrupt in U-mode with TW set is turned into an illegal-instruction trap. A debug-return outside debug mode is illegal as well. Any other wait-for-interrupt parks the block in a sleep state until an enabled interrupt arrives.

A small state machine has two states, `ST_RUN` and `ST_SLEEP`. The transition RUN→SLEEP happens on a wait-for-interrupt that completes without a trap. The transition SLEEP→RUN happens when an enabled interrupt is taken. Every other case stays in the current state. A simple write port lets the core load the status word and the vector base.

Top module: `mtrap_unit`

## Requirements
- R1: After reset: privilege M (`priv_o`=2'b11), MIE=0, MPIE=0, MPP=2'b11, TW=0, cause 0, exception PC 0, vector base `MTVEC_RST`, and `sleeping`, `redirect` and `trap_taken` all 0.
- R2: A synchronous exception writes a cause word with bit 31 clear and the code in the low bits: 1 for fetch fault, 2 for illegal, 7 for store fault. Fetch fault beats illegal, and illegal beats store fault. Faults count only when `instr_valid` is high.
- R3: An interrupt is taken when `irq_req` is high and either MIE=1 or the privilege is U. The cause word then has bit 31 set and holds `irq_id` zero-extended in the low bits.
- R4: On any trap, after the clock edge: the privilege is M, MIE=0, MPIE=1, MPP holds the previous privilege (00 for U, 11 for M), and the exception PC holds `instr_pc`.
- R5: In the trap cycle, `trap_taken` and `redirect` are high (combinationally), and `redirect_pc` is the vector base with bits [1:0] cleared.
- R6: A wait-for-interrupt in U-mode with TW=1 is an illegal-instruction trap (code 2) into M-mode. It does not sleep.
- R7: A debug-return with `in_debug`=0 is an illegal-instruction trap (code 2). With `in_debug`=1 it changes nothing.
- R8: A machine-return in M-mode redirects to the exception PC. After the edge: MIE takes the old MPIE, MPIE=1, the privilege takes the old MPP, and MPP=00. A machine-return in U-mode is an illegal-instruction trap.
- R9: A wait-for-interrupt that does not trap sets `sleeping` from the next cycle. While asleep, instruction flags and faults are ignored. An enabled interrupt is taken while asleep and clears `sleeping`.
- R10: When an exception and an enabled interrupt occur in the same cycle, only the exception is taken.
- R11: A taken interrupt pre-empts the retiring instruction. A machine-return or wait-for-interrupt in that cycle has no effect of its own.
- R12: A write with `csr_sel`=0 loads MIE from bit 3, MPIE from bit 7, MPP from bits 12:11 (2'b11 keeps M, any other value gives U) and TW from bit 21. A write with `csr_sel`=1 loads the vector base. The write is dropped in a cycle that takes a trap or completes a machine-return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | An instruction retires this cycle |
| instr_pc | input | XLEN | PC of the retiring instruction, or of the next instruction when none retires |
| dec_wfi | input | 1 | Retiring instruction is wait-for-interrupt |
| dec_dret | input | 1 | Retiring instruction is debug-return |
| dec_mret | input | 1 | Retiring instruction is machine-return |
| dec_illegal | input | 1 | Retiring instruction failed decode |
| in_debug | input | 1 | Core is in debug mode |
| fetch_fault | input | 1 | Instruction-fetch access fault |
| store_fault | input | 1 | Store access fault |
| irq_req | input | 1 | Interrupt request |
| irq_id | input | ID_W | Interrupt ID (e.g. 3, 7, 11) |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 1 | 0: status word, 1: vector base |
| csr_wdata | input | XLEN | Write data |
| priv_o | output | 2 | Current privilege (00 U, 11 M) |
| mie_o | output | 1 | Interrupt enable |
| mpie_o | output | 1 | Previous interrupt enable |
| mpp_o | output | 2 | Previous privilege |
| tw_o | output | 1 | Wait-for-interrupt trap enable for U-mode |
| cause_o | output | XLEN | Trap cause word |
| epc_o | output | XLEN | Exception PC |
| tvec_o | output | XLEN | Trap vector base |
| trap_taken | output | 1 | A trap is taken this cycle |
| redirect | output | 1 | Fetch must jump to `redirect_pc` |
| redirect_pc | output | XLEN | Redirect target |
| sleeping | output | 1 | Waiting for an interrupt |

## Verification
The assertions assume that the decode flags describe one retiring instruction, so at most one of them is high in a cycle. They also assume that `instr_pc` is stable while it is sampled and that `irq_id` is meaningful whenever `irq_req` is high. The random stimulus picks exactly one instruction kind per cycle. It draws interrupt IDs only from 3, 7 and 11, and it raises fault strobes only together with `instr_valid`, except when the directed fault-priority case stacks all three error sources on one instruction. Random writes to the status word keep reaching U-mode and enabling interrupts, so the block never stays asleep with no way to wake.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_M = 2'b11
    } priv_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_SLEEP = 1'b1
    } slp_state_e;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_TVEC   = 1'b1
    } csr_sel_e;

    localparam int CAUSE_FETCH   = 1;
    localparam int CAUSE_ILLEGAL = 2;
    localparam int CAUSE_STORE   = 7;

    localparam int BIT_MIE    = 3;
    localparam int BIT_MPIE   = 7;
    localparam int BIT_MPP_LO = 11;
    localparam int BIT_TW     = 21;

endpackage

// File: rtl/mtrap_arb.sv
module mtrap_arb
    import mtrap_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic              asleep,
    input  logic              instr_valid,
    input  logic              dec_wfi,
    input  logic              dec_dret,
    input  logic              dec_mret,
    input  logic              dec_illegal,
    input  logic              in_debug,
    input  logic              fetch_fault,
    input  logic              store_fault,
    input  logic              irq_req,
    input  logic [CODE_W-1:0] irq_id,
    input  priv_e             priv,
    input  logic              mie,
    input  logic              tw,
    output logic              trap,
    output logic              trap_irq,
    output logic [CODE_W-1:0] code,
    output logic              mret_do,
    output logic              wfi_sleep
);

    logic              live;
    logic              in_u;
    logic              bad_op;
    logic              exc_hit;
    logic              irq_en;
    logic [CODE_W-1:0] exc_code;

    always_comb begin
        live   = instr_valid && !asleep;
        in_u   = (priv == PRIV_U);
        bad_op = dec_illegal
              || (dec_dret && !in_debug)
              || (dec_wfi  && in_u && tw)
              || (dec_mret && in_u);

        exc_hit  = 1'b0;
        exc_code = '0;
        if (live) begin
            if (fetch_fault) begin
                exc_hit  = 1'b1;
                exc_code = CODE_W'(CAUSE_FETCH);
            end else if (bad_op) begin
                exc_hit  = 1'b1;
                exc_code = CODE_W'(CAUSE_ILLEGAL);
            end else if (store_fault) begin
                exc_hit  = 1'b1;
                exc_code = CODE_W'(CAUSE_STORE);
            end
        end

        irq_en    = irq_req && (mie || in_u);
        trap      = exc_hit || irq_en;
        trap_irq  = !exc_hit && irq_en;
        code      = exc_hit ? exc_code : irq_id;
        mret_do   = live && dec_mret && !in_u && !trap;
        wfi_sleep = live && dec_wfi && !trap;
    end

endmodule

// File: rtl/mtrap_fsm.sv
module mtrap_fsm
    import mtrap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_sleep,
    input  logic wake,
    output logic asleep
);

    slp_state_e state_q;
    slp_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (go_sleep) state_d = ST_SLEEP;
            ST_SLEEP: if (wake)     state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_SLEEP: asleep = 1'b1;
            default:  asleep = 1'b0;
        endcase
    end

endmodule

// File: rtl/mtrap_csr.sv
module mtrap_csr
    import mtrap_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              CODE_W    = 5,
    parameter logic [XLEN-1:0] MTVEC_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap,
    input  logic              trap_irq,
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   pc,
    input  logic              mret_do,
    input  logic              we,
    input  logic              sel,
    input  logic [XLEN-1:0]   wdata,
    output priv_e             priv,
    output logic              mie,
    output logic              mpie,
    output priv_e             mpp,
    output logic              tw,
    output logic [XLEN-1:0]   cause,
    output logic [XLEN-1:0]   epc,
    output logic [XLEN-1:0]   tvec
);

    localparam int PAD_W = XLEN - 1 - CODE_W;

    logic [XLEN-1:0] cause_word;
    priv_e           wr_mpp;

    assign cause_word = {trap_irq, {PAD_W{1'b0}}, code};
    assign wr_mpp     = (wdata[BIT_MPP_LO+1:BIT_MPP_LO] == 2'b11) ? PRIV_M : PRIV_U;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            priv  <= PRIV_M;
            mie   <= 1'b0;
            mpie  <= 1'b0;
            mpp   <= PRIV_M;
            tw    <= 1'b0;
            cause <= '0;
            epc   <= '0;
            tvec  <= MTVEC_RST;
        end else if (trap) begin
            cause <= cause_word;
            epc   <= pc;
            mpp   <= priv;
            priv  <= PRIV_M;
            mpie  <= 1'b1;
            mie   <= 1'b0;
        end else if (mret_do) begin
            mie  <= mpie;
            mpie <= 1'b1;
            priv <= mpp;
            mpp  <= PRIV_U;
        end else if (we) begin
            if (csr_sel_e'(sel) == SEL_TVEC) begin
                tvec <= wdata;
            end else begin
                mie  <= wdata[BIT_MIE];
                mpie <= wdata[BIT_MPIE];
                mpp  <= wr_mpp;
                tw   <= wdata[BIT_TW];
            end
        end
    end

endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
    import mtrap_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              ID_W      = 5,
    parameter logic [XLEN-1:0] MTVEC_RST = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [XLEN-1:0] instr_pc,
    input  logic            dec_wfi,
    input  logic            dec_dret,
    input  logic            dec_mret,
    input  logic            dec_illegal,
    input  logic            in_debug,
    input  logic            fetch_fault,
    input  logic            store_fault,
    input  logic            irq_req,
    input  logic [ID_W-1:0] irq_id,
    input  logic            csr_we,
    input  logic            csr_sel,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [1:0]      priv_o,
    output logic            mie_o,
    output logic            mpie_o,
    output logic [1:0]      mpp_o,
    output logic            tw_o,
    output logic [XLEN-1:0] cause_o,
    output logic [XLEN-1:0] epc_o,
    output logic [XLEN-1:0] tvec_o,
    output logic            trap_taken,
    output logic            redirect,
    output logic [XLEN-1:0] redirect_pc,
    output logic            sleeping
);

    priv_e            priv_q;
    priv_e            mpp_q;
    logic             trap;
    logic             trap_irq;
    logic [ID_W-1:0]  code;
    logic             mret_do;
    logic             wfi_sleep;
    logic             asleep;

    mtrap_arb #(.CODE_W(ID_W)) u_arb (
        .asleep      (asleep),
        .instr_valid (instr_valid),
        .dec_wfi     (dec_wfi),
        .dec_dret    (dec_dret),
        .dec_mret    (dec_mret),
        .dec_illegal (dec_illegal),
        .in_debug    (in_debug),
        .fetch_fault (fetch_fault),
        .store_fault (store_fault),
        .irq_req     (irq_req),
        .irq_id      (irq_id),
        .priv        (priv_q),
        .mie         (mie_o),
        .tw          (tw_o),
        .trap        (trap),
        .trap_irq    (trap_irq),
        .code        (code),
        .mret_do     (mret_do),
        .wfi_sleep   (wfi_sleep)
    );

    mtrap_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_sleep (wfi_sleep),
        .wake     (trap),
        .asleep   (asleep)
    );

    mtrap_csr #(
        .XLEN      (XLEN),
        .CODE_W    (ID_W),
        .MTVEC_RST (MTVEC_RST)
    ) u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .trap     (trap),
        .trap_irq (trap_irq),
        .code     (code),
        .pc       (instr_pc),
        .mret_do  (mret_do),
        .we       (csr_we),
        .sel      (csr_sel),
        .wdata    (csr_wdata),
        .priv     (priv_q),
        .mie      (mie_o),
        .mpie     (mpie_o),
        .mpp      (mpp_q),
        .tw       (tw_o),
        .cause    (cause_o),
        .epc      (epc_o),
        .tvec     (tvec_o)
    );

    assign priv_o      = priv_q;
    assign mpp_o       = mpp_q;
    assign trap_taken  = trap;
    assign redirect    = trap || mret_do;
    assign redirect_pc = trap ? {tvec_o[XLEN-1:2], 2'b00} : epc_o;
    assign sleeping    = asleep;

endmodule

// File: rtl/mtrap_unit_chk.sv
module mtrap_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            instr_valid,
    input logic            dec_wfi,
    input logic            fetch_fault,
    input logic            irq_req,
    input logic [1:0]      priv_o,
    input logic            mie_o,
    input logic            mpie_o,
    input logic            tw_o,
    input logic [XLEN-1:0] cause_o,
    input logic [XLEN-1:0] epc_o,
    input logic            trap_taken,
    input logic            redirect,
    input logic [XLEN-1:0] redirect_pc,
    input logic            sleeping
);

    AST_TRAP_ENTRY_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> (priv_o == 2'b11) && !mie_o && mpie_o); // R4

    AST_TRAP_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> redirect && (redirect_pc[1:0] == 2'b00)); // R5

    AST_NO_INSTR_IS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken && !instr_valid) |=> cause_o[XLEN-1]); // R3

    AST_TW_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !sleeping && dec_wfi && (priv_o == 2'b00) && tw_o) |-> trap_taken); // R6

    AST_SLEEP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && irq_req && (mie_o || (priv_o == 2'b00))) |-> trap_taken); // R9

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && !irq_req) |-> !redirect); // R9

    AST_RETURN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && !trap_taken) |-> (redirect_pc == epc_o)); // R8

    AST_EXC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !sleeping && fetch_fault && irq_req) |=>
            (!cause_o[XLEN-1] && (cause_o[XLEN-2:0] == 1))); // R10

endmodule

bind mtrap_unit mtrap_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .dec_wfi     (dec_wfi),
    .fetch_fault (fetch_fault),
    .irq_req     (irq_req),
    .priv_o      (priv_o),
    .mie_o       (mie_o),
    .mpie_o      (mpie_o),
    .tw_o        (tw_o),
    .cause_o     (cause_o),
    .epc_o       (epc_o),
    .trap_taken  (trap_taken),
    .redirect    (redirect),
    .redirect_pc (redirect_pc),
    .sleeping    (sleeping)
);

// File: tb/mtrap_unit_tb.sv
module mtrap_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_pc = '0;
    logic        dec_wfi = 1'b0, dec_dret = 1'b0, dec_mret = 1'b0, dec_illegal = 1'b0;
    logic        in_debug = 1'b0, fetch_fault = 1'b0, store_fault = 1'b0;
    logic        irq_req = 1'b0;
    logic [4:0]  irq_id = '0;
    logic        csr_we = 1'b0, csr_sel = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [1:0]  priv_o, mpp_o;
    logic        mie_o, mpie_o, tw_o, trap_taken, redirect, sleeping;
    logic [31:0] cause_o, epc_o, tvec_o, redirect_pc;

    int total = 0;
    int fails = 0;

    // reference state
    logic [1:0]  m_priv, m_mpp;
    logic        m_mie, m_mpie, m_tw, m_sleep;
    logic [31:0] m_cause, m_epc, m_tvec;

    always #5 clk = ~clk;

    mtrap_unit #(.XLEN(32), .ID_W(5), .MTVEC_RST(32'h0000_0100)) u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_pc(instr_pc),
        .dec_wfi(dec_wfi), .dec_dret(dec_dret), .dec_mret(dec_mret), .dec_illegal(dec_illegal),
        .in_debug(in_debug), .fetch_fault(fetch_fault), .store_fault(store_fault),
        .irq_req(irq_req), .irq_id(irq_id), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .priv_o(priv_o), .mie_o(mie_o), .mpie_o(mpie_o),
        .mpp_o(mpp_o), .tw_o(tw_o), .cause_o(cause_o), .epc_o(epc_o), .tvec_o(tvec_o),
        .trap_taken(trap_taken), .redirect(redirect), .redirect_pc(redirect_pc),
        .sleeping(sleeping)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [1:0] priv_of(input logic [1:0] raw);
        return (raw == 2'b11) ? 2'b11 : 2'b00;
    endfunction

    // Drives one cycle at the falling edge, checks the same-cycle outputs,
    // advances the reference state and checks registers after the rising edge.
    task automatic cyc(input logic v, input logic wfi, input logic dret, input logic mret,
                       input logic ill, input logic dbg, input logic ff, input logic sf,
                       input logic irq, input logic [4:0] id, input logic we,
                       input logic sel, input logic [31:0] wd, input logic [31:0] pc);
        logic       live, in_u, bad, exc, irq_en, trap, ret, go_sleep;
        logic [4:0] code;
        string      tg;
        @(negedge clk);
        instr_valid = v; dec_wfi = wfi; dec_dret = dret; dec_mret = mret;
        dec_illegal = ill; in_debug = dbg; fetch_fault = ff; store_fault = sf;
        irq_req = irq; irq_id = id; csr_we = we; csr_sel = sel; csr_wdata = wd;
        instr_pc = pc;
        #2;
        live = v && !m_sleep;
        in_u = (m_priv == 2'b00);
        bad  = ill || (dret && !dbg) || (wfi && in_u && m_tw) || (mret && in_u);
        exc  = live && (ff || bad || sf);
        code = ff ? 5'd1 : (bad ? 5'd2 : 5'd7);
        irq_en = irq && (m_mie || in_u);
        trap = exc || irq_en;
        ret  = live && mret && !in_u && !trap;
        go_sleep = live && wfi && !trap;
        tg = "R4";
        if (m_sleep) tg = "R9";
        else if (exc && irq_en) tg = "R10";
        else if (exc && ff) tg = "R2";
        else if (exc && ill) tg = "R2";
        else if (exc && dret && !dbg) tg = "R7";
        else if (exc && wfi && in_u && m_tw) tg = "R6";
        else if (exc && mret && in_u) tg = "R8";
        else if (exc) tg = "R2";
        else if (irq_en && v && (mret || wfi)) tg = "R11";
        else if (irq_en) tg = "R3";
        else if (ret) tg = "R8";
        else if (go_sleep) tg = "R9";
        else if (v && dret && dbg) tg = "R7";
        else if (we) tg = "R12";
        chk(tg, "trap_taken", 32'(trap_taken), 32'(trap));
        chk(tg, "redirect", 32'(redirect), 32'(trap || ret));
        if (trap) chk("R5", "redirect_pc", redirect_pc, {m_tvec[31:2], 2'b00});
        else if (ret) chk("R8", "redirect_pc", redirect_pc, m_epc);
        if (trap) begin
            m_cause = {!exc, 26'd0, exc ? code : id};
            m_epc   = pc;
            m_mpp   = m_priv;
            m_priv  = 2'b11;
            m_mpie  = 1'b1;
            m_mie   = 1'b0;
            m_sleep = 1'b0;
        end else if (ret) begin
            m_mie  = m_mpie;
            m_mpie = 1'b1;
            m_priv = m_mpp;
            m_mpp  = 2'b00;
        end else if (we) begin
            if (sel) m_tvec = wd;
            else begin
                m_mie  = wd[3];
                m_mpie = wd[7];
                m_mpp  = priv_of(wd[12:11]);
                m_tw   = wd[21];
            end
        end
        if (go_sleep) m_sleep = 1'b1;
        @(posedge clk);
        #1;
        chk(tg, "priv", 32'(priv_o), 32'(m_priv));
        chk(tg, "mie", 32'(mie_o), 32'(m_mie));
        chk(tg, "mpie", 32'(mpie_o), 32'(m_mpie));
        chk(tg, "mpp", 32'(mpp_o), 32'(m_mpp));
        chk(tg, "tw", 32'(tw_o), 32'(m_tw));
        chk(tg, "cause", cause_o, m_cause);
        chk(tg, "epc", epc_o, m_epc);
        chk(tg, "tvec", tvec_o, m_tvec);
        chk(tg, "sleeping", 32'(sleeping), 32'(m_sleep));
    endtask

    task automatic idle();
        cyc(0,0,0,0,0,0,0,0, 0,5'd0, 0,0,32'd0, 32'h40);
    endtask

    initial begin
        #2_000_000;
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        m_priv = 2'b11; m_mpp = 2'b11; m_mie = 0; m_mpie = 0; m_tw = 0; m_sleep = 0;
        m_cause = 0; m_epc = 0; m_tvec = 32'h0000_0100;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "priv", 32'(priv_o), 32'd3);
        chk("R1", "mie", 32'(mie_o), 32'd0);
        chk("R1", "mpie", 32'(mpie_o), 32'd0);
        chk("R1", "mpp", 32'(mpp_o), 32'd3);
        chk("R1", "tw", 32'(tw_o), 32'd0);
        chk("R1", "cause", cause_o, 32'd0);
        chk("R1", "epc", epc_o, 32'd0);
        chk("R1", "tvec", tvec_o, 32'h100);
        chk("R1", "sleeping", 32'(sleeping), 32'd0);
        chk("R1", "redirect", 32'(redirect), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        idle();

        // R12 vector base write with low bits set
        cyc(0,0,0,0,0,0,0,0, 0,5'd0, 1,1,32'h0000_1003, 32'h44);
        // R10 / R2 every error source plus an interrupt: fetch fault wins
        cyc(1,0,0,0,1,0,1,1, 1,5'd11, 0,0,32'd0, 32'h48);
        // R8 return to M
        cyc(1,0,0,1,0,0,0,0, 0,5'd0, 0,0,32'd0, 32'h1000);
        // R12 status write: MPP=U, TW=1, MIE=0
        cyc(0,0,0,0,0,0,0,0, 0,5'd0, 1,0,32'h0020_0000, 32'h50);
        cyc(1,0,0,1,0,0,0,0, 0,5'd0, 0,0,32'd0, 32'h54);
        // R6 WFI in U with TW set
        cyc(1,1,0,0,0,0,0,0, 0,5'd0, 0,0,32'd0, 32'h200);
        cyc(1,0,0,1,0,0,0,0, 0,5'd0, 0,0,32'd0, 32'h1000);
        // R8 return in U is illegal
        cyc(1,0,0,1,0,0,0,0, 0,5'd0, 0,0,32'd0, 32'h204);
        // R9 WFI in M sleeps; flags ignored while asleep; interrupt wakes
        cyc(1,1,0,0,0,0,0,0, 0,5'd0, 0,0,32'd0, 32'h300);
        cyc(1,0,0,1,1,0,1,0, 0,5'd0, 0,0,32'd0, 32'h304);
        cyc(0,0,0,0,0,0,0,0, 1,5'd7, 0,0,32'd0, 32'h304);
        cyc(0,0,0,0,0,0,0,0, 0,5'd0, 1,0,32'h0000_1808, 32'h304);
        cyc(0,0,0,0,0,0,0,0, 1,5'd7, 0,0,32'd0, 32'h304);
        // R7 debug-return inside and outside debug mode
        cyc(1,0,1,0,0,1,0,0, 0,5'd0, 0,0,32'd0, 32'h400);
        cyc(1,0,1,0,0,0,0,0, 0,5'd0, 0,0,32'd0, 32'h404);
        // R11 interrupt pre-empts a return
        cyc(0,0,0,0,0,0,0,0, 1,5'd0, 1,0,32'h0000_1888, 32'h408);
        cyc(1,0,0,1,0,0,0,0, 1,5'd3, 0,0,32'd0, 32'h40c);
        // R12 write dropped in a trap cycle
        cyc(1,0,0,0,1,0,0,0, 0,5'd0, 1,1,32'h0000_7770, 32'h410);
        // R3 interrupt with no instruction
        cyc(0,0,0,0,0,0,0,0, 0,5'd0, 1,0,32'h0000_0008, 32'h414);
        cyc(0,0,0,0,0,0,0,0, 1,5'd11, 0,0,32'd0, 32'h418);

        for (int i = 0; i < 3000; i++) begin
            int          k;
            logic        ir, dbg;
            logic [4:0]  idv;
            logic [31:0] pcv, wdv;
            k   = $urandom % 12;
            ir  = ($urandom % 4) == 0;
            dbg = $urandom % 2;
            idv = (($urandom % 3) == 0) ? 5'd3 : ((($urandom % 2) == 0) ? 5'd7 : 5'd11);
            pcv = $urandom & 32'hFFFF_FFFC;
            wdv = $urandom;
            case (k)
                0: cyc(0,0,0,0,0,0,0,0, ir,idv, 0,0,32'd0, pcv);
                1: cyc(1,0,0,0,0,0,0,0, ir,idv, 0,0,32'd0, pcv);
                2: cyc(1,1,0,0,0,0,0,0, ir,idv, 0,0,32'd0, pcv);
                3: cyc(1,0,1,0,0,dbg,0,0, ir,idv, 0,0,32'd0, pcv);
                4, 5: cyc(1,0,0,1,0,0,0,0, ir,idv, 0,0,32'd0, pcv);
                6: cyc(1,0,0,0,1,0,0,0, ir,idv, 0,0,32'd0, pcv);
                7: cyc(1,0,0,0,0,0,1,0, ir,idv, 0,0,32'd0, pcv);
                8: cyc(1,0,0,0,0,0,0,1, ir,idv, 0,0,32'd0, pcv);
                9, 10: cyc(0,0,0,0,0,0,0,0, ir,idv, 1,0,wdv, pcv);
                default: cyc(0,0,0,0,0,0,0,0, ir,idv, 1,1,wdv, pcv);
            endcase
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule